// File: doc/BRIEF.md
# Two-Stage Serial Clock Rate Generator

This block turns the peripheral clock into a stream of single-cycle edge ticks for a serial shift engine. Each tick marks one place where the engine toggles its serial clock, so two ticks make one serial clock period. The rate comes from two dividers in series. The first is an even prescaler and the second divides by one plus a post-divider value. A serial clock period is therefore `P * (1 + S)` peripheral clock cycles, and the peripheral clock divided by two is the fastest rate.

The prescaler field is 8 bits wide, but only even values from 2 to 254 are legal. The block clears bit 0 of the field, treats a value of zero as 2, and raises a flag whenever the raw field is odd or zero. Both counter stages restart from zero when the enable is low or when either configuration field differs from its value in the previous cycle. The tick train then begins again with a full half-period.

Top module: `sclk_rate_gen`

## Requirements
- R1: Reset clears both counters. While `en` is low, `edge_tick` stays low.
- R2: The effective prescaler is `presc_div` with bit 0 cleared, except that a raw value of 0 or 1 gives an effective prescaler of 2. For example, raw 7 acts as 6.
- R3: While `en` is high and the configuration is stable, consecutive ticks are exactly H = (P/2)*(1+S) cycles apart, where P is the effective prescaler and S is `post_div`. This gives two ticks per serial clock period.
- R4: With P = 2 and S = 0, `edge_tick` is high in every enabled cycle, which is the fastest serial rate (half the input clock).
- R5: After `en` rises with a stable configuration, the first tick comes in the H-th enabled cycle, counting the first enabled cycle as the 1st.
- R6: Lowering `en` suppresses ticks and clears both counters. When `en` rises again, the train restarts as in R5.
- R7: In a cycle where `presc_div` or `post_div` differs from its value in the previous cycle, no tick is issued and the counters restart. The first tick with the new settings comes H cycles later, counting the change cycle as cycle 0.
- R8: `presc_bad` is high, combinationally, exactly when `presc_div` is odd or zero.
- R9: While running, the prescaler stage count never exceeds P/2-1 and the post stage count never exceeds S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds both stages cleared |
| presc_div | input | PW (8) | Raw prescaler field, legal values even 2..254 |
| post_div | input | SW (8) | Post-divider value S; the second stage divides by 1+S |
| edge_tick | output | 1 | Single-cycle pulse at each serial clock edge position |
| presc_bad | output | 1 | High when the raw prescaler field is odd or zero |

## Verification
On every cycle, the assertions check the following:
- a tick appears only while the block is enabled and the configuration is steady;
- a tick coincides with the prescaler stage wrapping;
- both counters are zero after a tick and after the enable is low;
- both counters stay within their limits.

Only the bench's scenarios can show the following, because they depend on counting tick spacing across many cycles and on the arithmetic that maps raw fields to an interval:
- the exact tick spacing;
- the position of the first tick after enable or after a configuration change;
- the mapping of odd and zero prescaler values.

// File: rtl/sclk_rate_pkg.sv
package sclk_rate_pkg;

  // Effective prescaler: bit 0 cleared, zero promoted to two.
  function automatic logic [15:0] eff_presc(input logic [15:0] raw);
    logic [15:0] e;
    e = {raw[15:1], 1'b0};
    if (e == 16'd0) e = 16'd2;
    return e;
  endfunction

  // Cycles per prescaler-stage wrap (half the effective prescaler).
  function automatic logic [15:0] half_presc(input logic [15:0] raw);
    return eff_presc(raw) >> 1;
  endfunction

  // Raw prescaler values outside the legal even 2..254 set.
  function automatic logic presc_illegal(input logic [15:0] raw);
    return raw[0] | (raw == 16'd0);
  endfunction

endpackage

// File: rtl/sclk_cfg_watch.sv
module sclk_cfg_watch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg,
  output logic         changed
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  assign changed = (cfg != cfg_q);
endmodule

// File: rtl/sclk_div_stage.sv
module sclk_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = adv & (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (adv)   count <= wrap ? '0 : count + W'(1);
  end
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_rate_pkg::*;
#(
  parameter int PW = 8,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] presc_div,
  input  logic [SW-1:0] post_div,
  output logic          edge_tick,
  output logic          presc_bad
);
  localparam int C1W  = PW - 1;
  localparam int CFGW = PW + SW;

  logic           cfg_chg;
  logic           run;
  logic [C1W-1:0] lim1;
  logic [C1W-1:0] c1;
  logic [SW-1:0]  c2;
  logic           pre_tick;
  logic           post_wrap;

  sclk_cfg_watch #(.W(CFGW)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     ({presc_div, post_div}),
    .changed (cfg_chg)
  );

  assign run  = en & ~cfg_chg;
  assign lim1 = C1W'(half_presc(16'(presc_div)) - 16'd1);

  sclk_div_stage #(.W(C1W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (~run),
    .adv   (1'b1),
    .limit (lim1),
    .count (c1),
    .wrap  (pre_tick)
  );

  sclk_div_stage #(.W(SW)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (~run),
    .adv   (pre_tick),
    .limit (post_div),
    .count (c2),
    .wrap  (post_wrap)
  );

  assign edge_tick = run & post_wrap;
  assign presc_bad = presc_illegal(16'(presc_div));
endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk #(
  parameter int PW = 8,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          cfg_chg,
  input logic          edge_tick,
  input logic          pre_tick,
  input logic [PW-2:0] c1,
  input logic [PW-2:0] lim1,
  input logic [SW-1:0] c2,
  input logic [SW-1:0] post_div
);
  p_tick_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> en);

  p_idle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (c1 == '0 && c2 == '0));

  p_tick_on_pre_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |-> pre_tick);

  p_tick_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |=> (c1 == '0 && c2 == '0));

  p_no_tick_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |-> !edge_tick);

  p_change_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (c1 == '0 && c2 == '0));

  p_pre_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_chg) |-> (c1 <= lim1));

  p_post_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_chg) |-> (c2 <= post_div));
endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.PW(PW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .cfg_chg   (cfg_chg),
  .edge_tick (edge_tick),
  .pre_tick  (pre_tick),
  .c1        (c1),
  .lim1      (lim1),
  .c2        (c2),
  .post_div  (post_div)
);

// File: tb/test_sclk_rate_gen.sv
`timescale 1ns/1ps
module test_sclk_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] presc_div = 8'd2;
  logic [7:0] post_div = 8'd0;
  logic       edge_tick;
  logic       presc_bad;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  sclk_rate_gen #(.PW(8), .SW(8)) i_sclk_rate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .presc_div(presc_div),
    .post_div(post_div), .edge_tick(edge_tick), .presc_bad(presc_bad)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Samples the current cycle at the falling edge, then moves to just after the next rising edge.
  task automatic cyc(output bit t);
    @(negedge clk);
    t = edge_tick;
    @(posedge clk);
    #1;
  endtask

  // Independent restatement of the interval: half prescaler times (1+S).
  function automatic int interval(input int p, input int s);
    int e;
    e = (p / 2) * 2;
    if (e == 0) e = 2;
    return (e / 2) * (s + 1);
  endfunction

  // Checks n full intervals of h cycles, with ticks expected at the end of each.
  task automatic train(input int h, input int n, input string req);
    int  miss = 0;
    int  first = -1;
    int  cnt = 0;
    bit  t;
    for (int i = 0; i < h * n; i++) begin
      cyc(t);
      if (t) cnt++;
      if (t != (((i + 1) % h) == 0)) begin
        miss++;
        if (first < 0) first = i;
      end
    end
    check(miss == 0, req, first, -1);
    check(cnt == n, req, cnt, n);
  endtask

  task automatic configure(input int p, input int s);
    bit t;
    en = 1'b0;
    presc_div = 8'(p);
    post_div = 8'(s);
    cyc(t);
    cyc(t);
    en = 1'b1;
  endtask

  task automatic t_reset();
    bit t;
    int seen = 0;
    @(negedge clk);
    check(edge_tick == 1'b0, "R1 tick in reset", edge_tick, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc(t);
      if (t) seen++;
    end
    check(seen == 0, "R1 idle while en low", seen, 0);
  endtask

  task automatic t_basic();
    configure(6, 2);
    check(presc_bad == 1'b0, "R8 legal 6", presc_bad, 0);
    train(interval(6, 2), 4, "R5/R3 p6 s2");
    configure(254, 0);
    train(interval(254, 0), 2, "R3 p254 s0");
    configure(4, 255);
    train(interval(4, 255), 2, "R3 p4 s255");
  endtask

  task automatic t_fastest();
    configure(2, 0);
    train(1, 20, "R4 every cycle");
  endtask

  task automatic t_illegal();
    configure(7, 1);
    check(presc_bad == 1'b1, "R8 odd flagged", presc_bad, 1);
    train(6, 3, "R2 raw7 acts as 6");
    configure(0, 3);
    check(presc_bad == 1'b1, "R8 zero flagged", presc_bad, 1);
    train(4, 3, "R2 raw0 acts as 2");
    configure(1, 2);
    check(presc_bad == 1'b1, "R8 one flagged", presc_bad, 1);
    train(3, 3, "R2 raw1 acts as 2");
  endtask

  task automatic t_disable();
    bit t;
    int seen = 0;
    configure(4, 2);
    train(6, 1, "R6 before pause");
    cyc(t);
    cyc(t);
    en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      cyc(t);
      if (t) seen++;
    end
    check(seen == 0, "R6 no tick while disabled", seen, 0);
    en = 1'b1;
    train(6, 2, "R6 restart after enable");
  endtask

  task automatic t_change();
    bit t;
    configure(4, 1);
    train(4, 1, "R7 before change");
    cyc(t);
    cyc(t);
    cyc(t);
    post_div = 8'd2;
    cyc(t);
    check(t == 1'b0, "R7 quiet change cycle", t, 0);
    train(6, 2, "R7 post change");
    presc_div = 8'd8;
    cyc(t);
    check(t == 1'b0, "R7 quiet presc change", t, 0);
    train(interval(8, 2), 2, "R7 presc change");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_basic();
    t_fastest();
    t_illegal();
    t_disable();
    t_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule